// File: doc/BRIEF.md
# Privileged Special-Register Bank

This block holds the special-purpose registers of a 64-bit fixed-point core together with its machine-state register. It carries out move-to and move-from operations on them. Each operation arrives as a 10-bit register field taken straight from the instruction, a 64-bit source operand, a write or read strobe, a select that targets the machine-state register, and the current user-mode flag. The block rebuilds the register number from the field. It decides whether the access is allowed, and it either commits the write or returns the read value one cycle later. A refused access raises one of two trap flags in the same cycle as the strobe.

The storage-fault path of the core also feeds the bank. When a fault is reported, the fault-address register loads the faulting address and the fault-cause register loads the cause word. The interrupt-enable bit of the machine-state register gates a pending external interrupt into an interrupt request. That request reacts in the cycle after the write that sets the bit.

Top module: `spr_bank`

## Requirements
- R1: The register number is the instruction field with its two 5-bit halves exchanged: number = {field[4:0], field[9:5]}.
- R2: Bit 4 (weight 16) of the number marks a privileged register. With `user_mode`=1, a strobe to a defined privileged number raises `priv_trap`, leaves the register unchanged, and a read returns zero.
- R3: The defined numbers are 1, 8, 9, 18, 19, 22, 26, 27 and 272 to 275. Numbers 18 and 22 are 32 bits wide and the rest are 64 bits wide. Numbers 1, 8 and 9 are open to user mode.
- R4: A write to a 32-bit register keeps only bits 31:0 of the source. A read of a 32-bit register returns it in bits 31:0 with bits 63:32 equal to zero.
- R5: An undefined number changes no state and reads back zero. In user mode with bit 4 set it raises `priv_trap`. In every other case it raises `ill_trap`. The two flags are never high together, and both are low when no strobe is active.
- R6: `rd_data` updates on the clock edge that samples `rd_stb` and holds its value until the next read. A read that raises either trap returns zero.
- R7: With `msr_sel`=1 the strobe targets the machine-state register and the field is ignored. In user mode such an access raises `priv_trap` and leaves the register unchanged.
- R8: Bit 15 of the machine-state register enables interrupts: `irq_req` = `ext_pend` AND that bit. It is high from the cycle after the write that sets the bit.
- R9: `fault_stb` loads register 19 with `fault_addr` and register 18 with `fault_cause`. When bit 63 of the machine-state register is 0 (32-bit mode), bits 63:32 of register 19 are cleared.
- R10: When a fault and a software write to register 18 or 19 fall in the same cycle, the fault value is stored.
- R11: After reset every register, the machine-state register and `rd_data` are zero, and no trap or request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| spr_field | input | 10 | Register field with halves exchanged |
| wr_stb | input | 1 | Move-to strobe |
| rd_stb | input | 1 | Move-from strobe |
| msr_sel | input | 1 | Target machine-state register |
| src_data | input | 64 | Source operand |
| user_mode | input | 1 | Problem-state flag |
| fault_stb | input | 1 | Storage-fault report |
| fault_addr | input | 64 | Faulting effective address |
| fault_cause | input | 32 | Fault cause word |
| ext_pend | input | 1 | External interrupt pending |
| rd_data | output | 64 | Registered read result |
| priv_trap | output | 1 | Privileged-access trap |
| ill_trap | output | 1 | Illegal-form trap |
| irq_req | output | 1 | Interrupt request |

## Verification
A hardware fault report and a software move-to the fault-address or fault-cause register can arrive in the same cycle. The bench provokes this by raising `fault_stb` during a write strobe aimed at register 19 and, separately, at register 18. It then reads both registers back and expects the fault values, not the operand. The bench also sweeps all 1024 field values for writes and reads in both modes and compares every trap flag and read value against a model built from the rebuilt number.

// File: rtl/spr_bank_pkg.sv
package spr_bank_pkg;
    localparam int XLEN      = 64;
    localparam int NARROW    = 32;
    localparam int NUM_W     = 10;
    localparam int HALF      = NUM_W / 2;
    localparam int NREG      = 12;
    localparam int IDX_W     = $clog2(NREG);
    localparam int PRIV_BIT  = 4;
    localparam int MSR_EE    = 15;
    localparam int MSR_WIDE  = 63;
    localparam int CAUSE_IDX = 3;
    localparam int ADDR_IDX  = 4;

    typedef struct packed {
        logic             defined;
        logic             priv;
        logic             narrow;
        logic [IDX_W-1:0] idx;
    } spr_info_t;

    typedef struct packed {
        logic [NREG-1:0][XLEN-1:0] regs;
        logic [XLEN-1:0]           msr;
        logic [XLEN-1:0]           rdata;
    } bank_state_t;

    function automatic spr_info_t spr_lookup(input logic [NUM_W-1:0] num);
        spr_info_t r;
        r.defined = 1'b1;
        r.priv    = num[PRIV_BIT];
        r.narrow  = 1'b0;
        r.idx     = '0;
        case (num)
            10'd1:   r.idx = IDX_W'(0);
            10'd8:   r.idx = IDX_W'(1);
            10'd9:   r.idx = IDX_W'(2);
            10'd18:  begin r.idx = IDX_W'(CAUSE_IDX); r.narrow = 1'b1; end
            10'd19:  r.idx = IDX_W'(ADDR_IDX);
            10'd22:  begin r.idx = IDX_W'(5); r.narrow = 1'b1; end
            10'd26:  r.idx = IDX_W'(6);
            10'd27:  r.idx = IDX_W'(7);
            10'd272: r.idx = IDX_W'(8);
            10'd273: r.idx = IDX_W'(9);
            10'd274: r.idx = IDX_W'(10);
            10'd275: r.idx = IDX_W'(11);
            default: r.defined = 1'b0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/spr_decode.sv
module spr_decode
    import spr_bank_pkg::*;
(
    input  logic [NUM_W-1:0] field,
    output logic [NUM_W-1:0] num,
    output spr_info_t        info
);
    for (genvar b = 0; b < HALF; b++) begin : g_swap
        assign num[b + HALF] = field[b];
        assign num[b]        = field[b + HALF];
    end

    assign info = spr_lookup(num);
endmodule

// File: rtl/spr_guard.sv
module spr_guard
    import spr_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM_W-1:0] num,
    input  spr_info_t        info,
    input  logic             wr_stb,
    input  logic             rd_stb,
    input  logic             msr_sel,
    input  logic             user_mode,
    output logic             priv_trap,
    output logic             ill_trap
);
    logic access;
    assign access = wr_stb | rd_stb;

    always_comb begin
        priv_trap = 1'b0;
        ill_trap  = 1'b0;
        if (access) begin
            if (msr_sel) begin
                priv_trap = user_mode;
            end else if (info.defined) begin
                priv_trap = user_mode & info.priv;
            end else begin
                priv_trap = user_mode & num[PRIV_BIT];
                ill_trap  = ~priv_trap;
            end
        end
    end

    // R5
    trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({priv_trap, ill_trap}));

    // R7
    user_msr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_sel && user_mode && (wr_stb || rd_stb)) |-> priv_trap);

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb || rd_stb) |-> !(priv_trap || ill_trap));
endmodule

// File: rtl/spr_bank.sv
module spr_bank
    import spr_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM_W-1:0] spr_field,
    input  logic             wr_stb,
    input  logic             rd_stb,
    input  logic             msr_sel,
    input  logic [XLEN-1:0]  src_data,
    input  logic             user_mode,
    input  logic             fault_stb,
    input  logic [XLEN-1:0]  fault_addr,
    input  logic [NARROW-1:0] fault_cause,
    input  logic             ext_pend,
    output logic [XLEN-1:0]  rd_data,
    output logic             priv_trap,
    output logic             ill_trap,
    output logic             irq_req
);
    logic [NUM_W-1:0] num;
    spr_info_t        info;
    bank_state_t      st_d, st_q;
    logic             trapped;

    spr_decode u_decode (
        .field (spr_field),
        .num   (num),
        .info  (info)
    );

    spr_guard u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .num       (num),
        .info      (info),
        .wr_stb    (wr_stb),
        .rd_stb    (rd_stb),
        .msr_sel   (msr_sel),
        .user_mode (user_mode),
        .priv_trap (priv_trap),
        .ill_trap  (ill_trap)
    );

    assign trapped = priv_trap | ill_trap;

    always_comb begin
        st_d = st_q;
        if (wr_stb && !trapped) begin
            if (msr_sel) begin
                st_d.msr = src_data;
            end else if (info.defined) begin
                if (info.narrow)
                    st_d.regs[info.idx] = {{(XLEN-NARROW){1'b0}}, src_data[NARROW-1:0]};
                else
                    st_d.regs[info.idx] = src_data;
            end
        end
        if (fault_stb) begin
            st_d.regs[CAUSE_IDX] = {{(XLEN-NARROW){1'b0}}, fault_cause};
            if (st_q.msr[MSR_WIDE])
                st_d.regs[ADDR_IDX] = fault_addr;
            else
                st_d.regs[ADDR_IDX] = {{(XLEN-NARROW){1'b0}}, fault_addr[NARROW-1:0]};
        end
        if (rd_stb) begin
            if (trapped)
                st_d.rdata = '0;
            else if (msr_sel)
                st_d.rdata = st_q.msr;
            else if (info.defined)
                st_d.rdata = st_q.regs[info.idx];
            else
                st_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rdata;
    assign irq_req = ext_pend & st_q.msr[MSR_EE];

    // R6
    trap_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && (priv_trap || ill_trap)) |=> (rd_data == '0));

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && rd_stb));

    // R4
    narrow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !msr_sel && info.narrow) |=> (rd_data[XLEN-1:NARROW] == '0));

    // R9
    fault_narrow_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_stb && !st_q.msr[MSR_WIDE]) |=> (st_q.regs[ADDR_IDX][XLEN-1:NARROW] == '0));

    // R7
    msr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_sel && wr_stb && priv_trap) |=> $stable(st_q.msr));

    // R8
    irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && msr_sel && !user_mode && src_data[MSR_EE] && ext_pend)
        |=> (irq_req || !ext_pend));
endmodule

// File: tb/spr_bank_tb.sv
module spr_bank_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  spr_field = '0;
    logic        wr_stb = 1'b0, rd_stb = 1'b0, msr_sel = 1'b0, user_mode = 1'b0;
    logic [63:0] src_data = '0;
    logic        fault_stb = 1'b0;
    logic [63:0] fault_addr = '0;
    logic [31:0] fault_cause = '0;
    logic        ext_pend = 1'b0;
    logic [63:0] rd_data;
    logic        priv_trap, ill_trap, irq_req;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [63:0] model [0:1023];
    logic        got_priv, got_ill;

    always #(CLK_PERIOD/2) clk = ~clk;

    spr_bank u_dut (
        .clk(clk), .rst_n(rst_n), .spr_field(spr_field), .wr_stb(wr_stb),
        .rd_stb(rd_stb), .msr_sel(msr_sel), .src_data(src_data),
        .user_mode(user_mode), .fault_stb(fault_stb), .fault_addr(fault_addr),
        .fault_cause(fault_cause), .ext_pend(ext_pend), .rd_data(rd_data),
        .priv_trap(priv_trap), .ill_trap(ill_trap), .irq_req(irq_req)
    );

    function automatic bit is_def(input int n);
        return (n == 1 || n == 8 || n == 9 || n == 18 || n == 19 || n == 22 ||
                n == 26 || n == 27 || (n >= 272 && n <= 275));
    endfunction

    function automatic bit is_narrow(input int n);
        return (n == 18 || n == 22);
    endfunction

    function automatic logic [9:0] to_field(input int n);
        logic [9:0] v;
        v = 10'(n);
        return {v[4:0], v[9:5]};
    endfunction

    function automatic logic [63:0] pat(input int n, input logic [63:0] salt);
        return 64'h0123_4567_89AB_CDEF ^ (64'(n) * 64'h9E37_79B9_7F4A_7C15) ^ salt;
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic op(input bit w, input bit r, input bit ms, input logic [9:0] f,
                      input logic [63:0] d, input bit um);
        @(negedge clk);
        wr_stb = w; rd_stb = r; msr_sel = ms; spr_field = f; src_data = d; user_mode = um;
        #1;
        got_priv = priv_trap;
        got_ill  = ill_trap;
        @(posedge clk);
        #1;
        wr_stb = 1'b0; rd_stb = 1'b0; msr_sel = 1'b0;
    endtask

    task automatic exp_traps(input int n, input bit um, output bit ep, output bit ei);
        logic [9:0] v;
        v  = 10'(n);
        ep = um & v[4];
        ei = !is_def(n) && !ep;
    endtask

    task automatic sweep_write(input bit um, input logic [63:0] salt);
        for (int n = 0; n < 1024; n++) begin
            bit ep, ei;
            op(1'b1, 1'b0, 1'b0, to_field(n), pat(n, salt), um);
            exp_traps(n, um, ep, ei);
            chk(is_def(n) ? "R2 write trap" : "R5 write trap", {62'd0, got_priv, got_ill}, {62'd0, ep, ei});
            if (is_def(n) && !ep)
                model[n] = is_narrow(n) ? {32'd0, pat(n, salt)[31:0]} : pat(n, salt);
        end
    endtask

    task automatic sweep_read(input bit um);
        for (int n = 0; n < 1024; n++) begin
            bit ep, ei;
            op(1'b0, 1'b1, 1'b0, to_field(n), 64'hDEAD_BEEF_DEAD_BEEF, um);
            exp_traps(n, um, ep, ei);
            chk(is_def(n) ? "R1 R3 read trap" : "R5 read trap", {62'd0, got_priv, got_ill}, {62'd0, ep, ei});
            if (!is_def(n) || ep || ei)
                chk("R6 trapped/undefined read zero", rd_data, 64'd0);
            else if (is_narrow(n))
                chk("R4 narrow read", rd_data, model[n]);
            else
                chk("R1 R3 read value", rd_data, model[n]);
        end
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R11 reset state
        chk("R11 rd_data", rd_data, 64'd0);
        chk("R11 flags", {61'd0, priv_trap, ill_trap, irq_req}, 64'd0);
        op(1'b0, 1'b1, 1'b1, 10'd0, 64'd0, 1'b0);
        chk("R11 msr", rd_data, 64'd0);
        op(1'b0, 1'b1, 1'b0, to_field(273), 64'd0, 1'b0);
        chk("R11 reg", rd_data, 64'd0);

        // Supervisor sweep
        sweep_write(1'b0, 64'h0);
        sweep_read(1'b0);
        // User sweep: only 1, 8, 9 change
        sweep_write(1'b1, 64'hA5A5_0000_5A5A_FFFF);
        sweep_read(1'b1);
        sweep_read(1'b0);

        // R6 hold: a write does not disturb rd_data
        op(1'b0, 1'b1, 1'b0, to_field(8), 64'd0, 1'b0);
        op(1'b1, 1'b0, 1'b0, to_field(9), 64'h1111, 1'b0);
        model[9] = 64'h1111;
        chk("R6 hold", rd_data, model[8]);

        // R4 narrow write truncation
        op(1'b1, 1'b0, 1'b0, to_field(22), 64'hFFFF_FFFF_8765_4321, 1'b0);
        op(1'b0, 1'b1, 1'b0, to_field(22), 64'd0, 1'b0);
        chk("R4 truncate", rd_data, 64'h0000_0000_8765_4321);

        // R8 interrupt enable
        ext_pend = 1'b1;
        op(1'b1, 1'b0, 1'b1, 10'd0, 64'h0, 1'b0);
        chk("R8 disabled", {63'd0, irq_req}, 64'd0);
        @(negedge clk);
        wr_stb = 1'b1; msr_sel = 1'b1; src_data = 64'h0000_0000_0000_8000; user_mode = 1'b0;
        #1 chk("R8 before edge", {63'd0, irq_req}, 64'd0);
        @(posedge clk);
        #1 wr_stb = 1'b0; msr_sel = 1'b0;
        chk("R8 after write", {63'd0, irq_req}, 64'd1);
        ext_pend = 1'b0;
        #1 chk("R8 pend low", {63'd0, irq_req}, 64'd0);

        // R7 user access to msr
        op(1'b1, 1'b0, 1'b1, 10'h3FF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
        chk("R7 user msr write trap", {63'd0, got_priv}, 64'd1);
        op(1'b0, 1'b1, 1'b1, 10'd0, 64'd0, 1'b1);
        chk("R7 user msr read trap", {62'd0, got_priv, got_ill}, 64'd2);
        chk("R7 user msr read zero", rd_data, 64'd0);
        op(1'b0, 1'b1, 1'b1, 10'h155, 64'd0, 1'b0);
        chk("R7 msr unchanged", rd_data, 64'h0000_0000_0000_8000);

        // R9 fault in 32-bit mode
        fault_addr = 64'hFEDC_BA98_7654_3210; fault_cause = 32'hC0DE_0001; fault_stb = 1'b1;
        op(1'b0, 1'b0, 1'b0, 10'd0, 64'd0, 1'b0);
        fault_stb = 1'b0;
        op(1'b0, 1'b1, 1'b0, to_field(19), 64'd0, 1'b0);
        chk("R9 addr narrow mode", rd_data, 64'h0000_0000_7654_3210);
        op(1'b0, 1'b1, 1'b0, to_field(18), 64'd0, 1'b0);
        chk("R9 cause", rd_data, 64'h0000_0000_C0DE_0001);
        // R9 fault in 64-bit mode
        op(1'b1, 1'b0, 1'b1, 10'd0, 64'h8000_0000_0000_0000, 1'b0);
        fault_addr = 64'h1357_9BDF_2468_ACE0; fault_stb = 1'b1;
        op(1'b0, 1'b0, 1'b0, 10'd0, 64'd0, 1'b0);
        fault_stb = 1'b0;
        op(1'b0, 1'b1, 1'b0, to_field(19), 64'd0, 1'b0);
        chk("R9 addr wide mode", rd_data, 64'h1357_9BDF_2468_ACE0);

        // R10 fault and software write in the same cycle
        fault_addr = 64'hAAAA_BBBB_CCCC_DDDD; fault_cause = 32'h0BAD_F00D; fault_stb = 1'b1;
        op(1'b1, 1'b0, 1'b0, to_field(19), 64'h5555_5555_5555_5555, 1'b0);
        op(1'b1, 1'b0, 1'b0, to_field(18), 64'h7777_7777_7777_7777, 1'b0);
        fault_stb = 1'b0;
        op(1'b0, 1'b1, 1'b0, to_field(19), 64'd0, 1'b0);
        chk("R10 addr collision", rd_data, 64'hAAAA_BBBB_CCCC_DDDD);
        op(1'b0, 1'b1, 1'b0, to_field(18), 64'd0, 1'b0);
        chk("R10 cause collision", rd_data, 64'h0000_0000_0BAD_F00D);

        // R5 idle: no strobe, no trap
        @(negedge clk);
        spr_field = 10'h3FF; user_mode = 1'b1;
        #1 chk("R5 idle flags", {62'd0, priv_trap, ill_trap}, 64'd0);
        user_mode = 1'b0;

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog got=timeout exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule